// File: doc/BRIEF.md
# Embedded-Clock Framed Serializer and Deframer

This block sends parallel words over a single serial line without a separate clock wire. The transmit half takes a word through a valid/ready handshake into a holding register, then moves it into a shift register and sends it as a frame. Each frame opens with one full clock period on the line, a high bit then a low bit, and the data bits follow at once, most significant bit first. When no word is waiting at a frame boundary, a frame with all-zero data goes out instead, so the line always carries a start marker at a fixed period.

The receive half runs at the bit rate and scans the incoming line for the start marker. It first locks onto a low-high-low pattern. It then confirms that the high-low start pair repeats at the frame spacing for several frames before declaring lock. Once locked, it presents each recovered word with a one-cycle strobe. It counts missing start markers, and it gives up lock and searches again after a run of consecutive misses. Both halves share the bit clock, and a loopback between the serial output and input forms a complete link.

Top module: `ecf_serdes`

## Requirements
- R1: A frame is DATA_W+2 bits long: bit 0 is 1, bit 1 is 0, and bits 2 to DATA_W+1 are the word from bit DATA_W-1 down to bit 0. Frames follow each other with no gap.
- R2: The line is high in the first bit and low in the second bit of every frame. After reset is released, frame starts occur every DATA_W+2 clock cycles, counting from cycle 0.
- R3: A word is taken only when tx_valid_i and tx_ready_o are both high. After a word is taken, tx_ready_o is low. Taking a word while a frame is in flight does not change that frame.
- R4: tx_ready_o goes high again only at a frame boundary, in the cycle in which the held word moves into the shift register.
- R5: If no word is held when a frame starts, that frame carries all-zero data.
- R6: The deframer accepts a 0,1,0 bit sequence as a candidate start. It declares rx_locked_o when the 1,0 start pair appears at the frame spacing in the candidate frame and in the next LOCK_FRAMES-1 frames (4 frames in total by default). A mismatch during this confirmation restarts the search.
- R7: While locked, each frame with a correct start pair produces a one-cycle rx_valid_o pulse, with rx_data_o holding the frame's data bits reassembled in their original order.
- R8: rx_valid_o is never high while rx_locked_o is low.
- R9: While locked, a frame whose start pair is wrong produces no word and raises rx_err_cnt_o by one. The count saturates at its maximum.
- R10: MISS_LIMIT consecutive bad frames (3 by default) clear rx_locked_o and restart the search. A good frame resets the consecutive-miss run.
- R11: During reset, ser_o is 1 (the start of an idle frame), tx_ready_o is 1, and rx_locked_o, rx_valid_o and rx_err_cnt_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_data_i | input | DATA_W | Word to send |
| tx_valid_i | input | 1 | tx_data_i is valid |
| tx_ready_o | output | 1 | Holding register is free |
| ser_o | output | 1 | Serial line out |
| ser_i | input | 1 | Serial line in |
| rx_data_o | output | DATA_W | Recovered word |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| rx_locked_o | output | 1 | Deframer has frame lock |
| rx_err_cnt_o | output | ERR_W | Saturating count of missed start pairs while locked |

## Verification
The assertions check the following on every cycle:
- the high-low start pair sits at frame bits 0 and 1;
- a held word stays unchanged until it is taken;
- the ready signal frees only on a load;
- the valid pulse is a single cycle and only occurs while locked;
- the error count only steps by one;
- lock is entered only after the full confirmation count and left only after the full miss run.

Only the bench scenarios can show the rest:
- that words arrive intact and in order across the loopback;
- that idle frames appear on the line;
- when ready returns relative to the frame boundary;
- how the error count and lock respond to injected start-bit faults, including a run of misses broken by one good frame and the re-acquisition that follows a loss of lock.

// File: rtl/ecf_pkg.sv
package ecf_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH  = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_LOCKED  = 2'd2
  } rx_state_e;

  localparam logic [1:0] START_PAIR = 2'b10;
endpackage

// File: rtl/ecf_tx_hold.sv
module ecf_tx_hold #(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              take_i,
  output logic              ready_o,
  output logic              full_o,
  output logic [DATA_W-1:0] word_o
);
  logic              full_q;
  logic [DATA_W-1:0] word_q;
  logic              accept;

  assign accept  = valid_i & ~full_q;
  assign ready_o = ~full_q;
  assign full_o  = full_q;
  assign word_o  = word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      word_q <= '0;
    end else begin
      full_q <= accept | (full_q & ~take_i);
      if (accept) word_q <= data_i;
    end
  end

  // R3: a held word is kept intact until the shifter takes it
  p_hold_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !take_i) |=> (full_q && $stable(word_q)));
endmodule

// File: rtl/ecf_tx_shift.sv
module ecf_tx_shift #(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              full_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              take_o,
  output logic              ser_o
);
  import ecf_pkg::*;
  localparam int FL   = DATA_W + 2;
  localparam int CN_W = $clog2(FL);

  logic [FL-1:0]   sh_q;
  logic [CN_W-1:0] cnt_q;
  logic            last;

  assign last   = (cnt_q == CN_W'(FL - 1));
  assign take_o = last & full_i;
  assign ser_o  = sh_q[FL-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= {START_PAIR, {DATA_W{1'b0}}};
      cnt_q <= '0;
    end else if (last) begin
      sh_q  <= {START_PAIR, (full_i ? word_i : {DATA_W{1'b0}})};
      cnt_q <= '0;
    end else begin
      sh_q  <= {sh_q[FL-2:0], 1'b0};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_start_hi_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |-> ser_o);
  p_start_lo_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CN_W'(1)) |-> !ser_o);
  p_idle_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && !full_i) |=> (sh_q[DATA_W-1:0] == '0));
endmodule

// File: rtl/ecf_rx_deframer.sv
module ecf_rx_deframer #(
  parameter int DATA_W      = 10,
  parameter int LOCK_FRAMES = 4,
  parameter int MISS_LIMIT  = 3,
  parameter int ERR_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              locked_o,
  output logic [ERR_W-1:0]  err_cnt_o
);
  import ecf_pkg::*;
  localparam int FL   = DATA_W + 2;
  localparam int PH_W = $clog2(FL);
  localparam int GC_W = $clog2(LOCK_FRAMES + 1);
  localparam int MC_W = $clog2(MISS_LIMIT + 1);

  rx_state_e         st_q;
  logic [FL:0]       win_q;   // win_q[FL] is the bit before the frame
  logic [PH_W-1:0]   ph_q;
  logic [GC_W-1:0]   good_q;
  logic [MC_W-1:0]   miss_q;
  logic [ERR_W-1:0]  err_q;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              aligned, cand, start_ok;

  assign aligned  = (ph_q == PH_W'(FL - 1));
  assign cand     = (win_q[FL:FL-2] == 3'b010);
  assign start_ok = (win_q[FL-1:FL-2] == START_PAIR);

  assign data_o    = data_q;
  assign valid_o   = valid_q;
  assign locked_o  = (st_q == ST_LOCKED);
  assign err_cnt_o = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_SEARCH;
      win_q   <= '0;
      ph_q    <= '0;
      good_q  <= '0;
      miss_q  <= '0;
      err_q   <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      win_q   <= {win_q[FL-1:0], ser_i};
      valid_q <= 1'b0;
      unique case (st_q)
        ST_SEARCH: begin
          ph_q <= '0;
          if (cand) begin
            st_q   <= ST_CONFIRM;
            good_q <= GC_W'(1);
          end
        end
        ST_CONFIRM: begin
          ph_q <= aligned ? '0 : ph_q + 1'b1;
          if (aligned) begin
            if (!start_ok) begin
              st_q   <= ST_SEARCH;
              good_q <= '0;
            end else if (good_q == GC_W'(LOCK_FRAMES - 1)) begin
              st_q   <= ST_LOCKED;
              miss_q <= '0;
            end else begin
              good_q <= good_q + 1'b1;
            end
          end
        end
        ST_LOCKED: begin
          ph_q <= aligned ? '0 : ph_q + 1'b1;
          if (aligned) begin
            if (start_ok) begin
              valid_q <= 1'b1;
              data_q  <= win_q[DATA_W-1:0];
              miss_q  <= '0;
            end else begin
              if (err_q != '1) err_q <= err_q + 1'b1;
              if (miss_q == MC_W'(MISS_LIMIT - 1)) begin
                st_q   <= ST_SEARCH;
                good_q <= '0;
                miss_q <= '0;
              end else begin
                miss_q <= miss_q + 1'b1;
              end
            end
          end
        end
        default: st_q <= ST_SEARCH;
      endcase
    end
  end

  p_valid_locked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (st_q == ST_LOCKED));
  p_valid_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  p_err_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q != $past(err_q)) |-> (err_q == $past(err_q) + 1'b1));
  p_lock_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_LOCKED) && ($past(st_q) != ST_LOCKED))
      |-> ($past(good_q) == GC_W'(LOCK_FRAMES - 1)));
  p_drop_after_run_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_SEARCH) && ($past(st_q) == ST_LOCKED))
      |-> ($past(miss_q) == MC_W'(MISS_LIMIT - 1)));
  p_miss_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_q < MC_W'(MISS_LIMIT));
endmodule

// File: rtl/ecf_serdes.sv
module ecf_serdes #(
  parameter int DATA_W      = 10,
  parameter int LOCK_FRAMES = 4,
  parameter int MISS_LIMIT  = 3,
  parameter int ERR_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              ser_o,
  input  logic              ser_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              rx_locked_o,
  output logic [ERR_W-1:0]  rx_err_cnt_o
);
  logic              take, full;
  logic [DATA_W-1:0] held;

  ecf_tx_hold #(.DATA_W(DATA_W)) i_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .data_i  (tx_data_i),
    .valid_i (tx_valid_i),
    .take_i  (take),
    .ready_o (tx_ready_o),
    .full_o  (full),
    .word_o  (held)
  );

  ecf_tx_shift #(.DATA_W(DATA_W)) i_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .full_i (full),
    .word_i (held),
    .take_o (take),
    .ser_o  (ser_o)
  );

  ecf_rx_deframer #(
    .DATA_W      (DATA_W),
    .LOCK_FRAMES (LOCK_FRAMES),
    .MISS_LIMIT  (MISS_LIMIT),
    .ERR_W       (ERR_W)
  ) i_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ser_i     (ser_i),
    .data_o    (rx_data_o),
    .valid_o   (rx_valid_o),
    .locked_o  (rx_locked_o),
    .err_cnt_o (rx_err_cnt_o)
  );

  p_ready_on_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_ready_o) |-> $past(take));
endmodule

// File: tb/test_ecf_serdes.sv
module test_ecf_serdes;
  localparam int W = 10;
  localparam int FL = W + 2;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic         tx_valid = 1'b0;
  logic         flip = 1'b0;
  logic         tx_ready, ser_out, ser_in, rx_valid, rx_locked;
  logic [W-1:0] rx_data;
  logic [7:0]   rx_err;

  int n_chk = 0, n_fail = 0, cyc = 0, n_rx = 0, unlocked_valids = 0;
  bit done = 1'b0;
  int exp_q[$];

  assign ser_in = ser_out ^ flip;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  ecf_serdes i_ecf_serdes (
    .clk_i(clk), .rst_ni(rst_n), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .ser_o(ser_out), .ser_i(ser_in),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_locked_o(rx_locked),
    .rx_err_cnt_o(rx_err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: idle (zero) words are skipped
  always @(negedge clk) begin
    if (rst_n && rx_valid && !rx_locked) unlocked_valids++;
    if (rst_n && rx_valid && rx_data != '0) begin
      n_rx++;
      if (exp_q.size() == 0) check(1'b0, "R7 unexpected word", 32'(rx_data), 0);
      else begin
        int e;
        e = exp_q.pop_front();
        check(rx_data == W'(e), "R7 word", 32'(rx_data), 32'(e));
      end
    end
  end

  task automatic send_word(input logic [W-1:0] w);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data = w; tx_valid = 1'b1;
    exp_q.push_back(int'(w));
    @(negedge clk);
    tx_valid = 1'b0;
    check(!tx_ready, "R3 ready low after take", 32'(tx_ready), 0);
  endtask

  task automatic frame_start();
    @(negedge clk);
    while (cyc % FL != 0) @(negedge clk);
  endtask

  task automatic hit_start();
    frame_start();
    flip = 1'b1;
    @(negedge clk);
    flip = 1'b0;
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 40 * FL && exp_q.size() != 0; i++) @(negedge clk);
    repeat (2 * FL) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(ser_out == 1'b1, "R11 ser_o", 32'(ser_out), 1);
    check(tx_ready == 1'b1, "R11 ready", 32'(tx_ready), 1);
    check(!rx_locked && !rx_valid, "R11 rx idle", {30'd0, rx_locked, rx_valid}, 0);
    check(rx_err == '0, "R11 err", 32'(rx_err), 0);
    rst_n = 1'b1;

    // R1 R2 R5: two idle frames on the line
    for (int i = 0; i < 2 * FL; i++) begin
      check(ser_out == ((i % FL) == 0), "R1/R2/R5 idle frame bit", 32'(ser_out),
            32'((i % FL) == 0));
      @(negedge clk);
    end

    // R6 acquisition
    for (int i = 0; i < 10 * FL && !rx_locked; i++) @(negedge clk);
    check(rx_locked, "R6 lock acquired", 32'(rx_locked), 1);
    check(cyc >= 3 * FL && cyc <= 6 * FL, "R6 lock time", 32'(cyc), 32'(4 * FL));
    check(unlocked_valids == 0, "R8 no word before lock", 32'(unlocked_valids), 0);

    // R4: ready returns exactly at a frame boundary
    send_word(10'h3a5);
    while (!tx_ready) @(negedge clk);
    check(cyc % FL == 0, "R4 ready at boundary", 32'(cyc % FL), 0);

    // R3 R7: back-to-back words, taken mid-frame
    send_word(10'h001);
    send_word(10'h200);
    send_word(10'h2aa);
    send_word(10'h155);
    send_word(10'h3ff);
    wait_drain();
    check(exp_q.size() == 0, "R7 all words delivered", 32'(exp_q.size()), 0);
    check(n_rx == 6, "R3 word count", 32'(n_rx), 6);

    // R9: single start fault
    hit_start();
    repeat (2 * FL) @(negedge clk);
    check(rx_err == 8'd1, "R9 err count", 32'(rx_err), 1);
    check(rx_locked, "R9 lock kept", 32'(rx_locked), 1);

    // R10: two misses, one good frame, two misses keep lock
    hit_start(); hit_start();
    frame_start();
    hit_start(); hit_start();
    repeat (2 * FL) @(negedge clk);
    check(rx_err == 8'd5, "R10 err after broken run", 32'(rx_err), 5);
    check(rx_locked, "R10 lock kept by good frame", 32'(rx_locked), 1);

    // R10: three consecutive misses drop lock
    hit_start(); hit_start(); hit_start();
    repeat (FL + 2) @(negedge clk);
    check(!rx_locked, "R10 lock dropped", 32'(rx_locked), 0);
    check(rx_err == 8'd8, "R10 err after run", 32'(rx_err), 8);

    // R6: re-acquire, then data again
    for (int i = 0; i < 10 * FL && !rx_locked; i++) @(negedge clk);
    check(rx_locked, "R6 relock", 32'(rx_locked), 1);
    send_word(10'h0f0);
    send_word(10'h30c);
    wait_drain();
    check(exp_q.size() == 0, "R7 words after relock", 32'(exp_q.size()), 0);
    check(unlocked_valids == 0, "R8 no word while unlocked", 32'(unlocked_valids), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R7 watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule